// File: doc/BRIEF.md
# Dual-Port Hardware Lock Bank

This block holds a set of one-bit mutual-exclusion locks that two requesters share over a plain access interface. A requester takes a lock by reading that lock's address. The read is an atomic test-and-set. If the lock was free, the read returns a nonzero word and marks the lock held in the same access. If the lock was already held, the read returns zero and the lock stays held. Writing to a lock's address frees the lock. No data goes with the write.

Both ports may issue one access per cycle. The block settles contention inside that cycle with fixed rules. Releases are applied before claims, and port 0 outranks port 1 when both try to take the same free lock. A bitmap output shows which locks are held at any time.

Lock state is kept through the ordinary synchronous reset. Only a dedicated asynchronous power-on clear input empties the bank. Software can also empty it by writing every lock address.

Top module: `spinlock_bank`

## Requirements
- R1: A read of a free lock i returns rvalid=1 with rdata equal to the one-hot mask (bit i set, all others 0) on the cycle after the access.
- R2: After a successful read claim of lock i, bit i of lock_map is 1 from the cycle after the access.
- R3: A read of a held lock returns rvalid=1 with rdata=0, and the lock stays held.
- R4: A write access (we=1) to lock i frees it: bit i of lock_map is 0 from the next cycle. This holds unless the other port claims the same lock in the same cycle.
- R5: lock_map bit i is 1 exactly when lock i is held. It reads all zeros after power-on clear.
- R6: When both ports read the same free lock in one cycle, port 0 receives the mask and port 1 receives 0.
- R7: When one port writes lock i and the other port reads lock i in the same cycle, the release is applied first. The reader gets the mask and the lock ends up held.
- R8: Driving por_n low clears every lock at once, whatever state the bank was in.
- R9: While rst_n is low, accesses are ignored, lock_map keeps its value, and both rvalid outputs read 0 on the following cycle.
- R10: Locks are not re-entrant. A port that holds lock i and reads it again gets rdata=0.
- R11: A write produces no rvalid. A write to a free lock leaves it free.
- R12: Reads of two different free locks in the same cycle, one per port, both succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on clear, active low; empties the lock bank |
| rst_n | input | 1 | Synchronous reset, active low; clears responses only |
| p0_req | input | 1 | Port 0 access strobe |
| p0_we | input | 1 | Port 0 access kind: 0 = claim read, 1 = release write |
| p0_idx | input | IDX_W (5) | Port 0 lock number |
| p1_req | input | 1 | Port 1 access strobe |
| p1_we | input | 1 | Port 1 access kind: 0 = claim read, 1 = release write |
| p1_idx | input | IDX_W (5) | Port 1 lock number |
| p0_rvalid | output | 1 | Port 0 read response valid, one cycle after the read |
| p0_rdata | output | NUM_LOCKS (32) | Port 0 read response: lock mask on success, 0 on failure |
| p1_rvalid | output | 1 | Port 1 read response valid |
| p1_rdata | output | NUM_LOCKS (32) | Port 1 read response |
| lock_map | output | NUM_LOCKS (32) | Bitmap of held locks |

## Verification
The bench builds the block with its default of 32 locks, which gives 5-bit lock numbers. With that size, lock 31 sits in the top bit of the returned mask. This lets the bench claim and then free every lock one by one, so each bit of the bitmap and of both response words is exercised. Same-cycle collisions are driven with both ports aimed at one lock, which is how the claim-versus-claim and release-versus-claim ordering is checked.

// File: rtl/spl_pkg.sv
package spl_pkg;
    localparam int unsigned SPL_DEF_LOCKS = 32;
    localparam int unsigned SPL_PORTS     = 2;

    typedef enum logic {
        OP_CLAIM = 1'b0,
        OP_FREE  = 1'b1
    } spl_op_e;
endpackage

// File: rtl/spl_decode.sv
module spl_decode #(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic                 en,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_LOCKS-1:0] hit
);
    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_bit
        assign hit[i] = en && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/spl_resolve.sv
module spl_resolve #(
    parameter int unsigned NUM_LOCKS = 32
) (
    input  logic [NUM_LOCKS-1:0] held,
    input  logic [NUM_LOCKS-1:0] free_mask,
    input  logic [NUM_LOCKS-1:0] want0,
    input  logic [NUM_LOCKS-1:0] want1,
    output logic [NUM_LOCKS-1:0] grant0,
    output logic [NUM_LOCKS-1:0] grant1,
    output logic [NUM_LOCKS-1:0] held_next
);
    logic [NUM_LOCKS-1:0] after_rel;

    always_comb begin
        after_rel = held & ~free_mask;
        grant0    = want0 & ~after_rel;
        grant1    = want1 & ~after_rel & ~grant0;
        held_next = after_rel | grant0 | grant1;
    end
endmodule

// File: rtl/spinlock_bank.sv
module spinlock_bank
    import spl_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = SPL_DEF_LOCKS,
    localparam int unsigned IDX_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 rst_n,
    input  logic                 p0_req,
    input  logic                 p0_we,
    input  logic [IDX_W-1:0]     p0_idx,
    input  logic                 p1_req,
    input  logic                 p1_we,
    input  logic [IDX_W-1:0]     p1_idx,
    output logic                 p0_rvalid,
    output logic [NUM_LOCKS-1:0] p0_rdata,
    output logic                 p1_rvalid,
    output logic [NUM_LOCKS-1:0] p1_rdata,
    output logic [NUM_LOCKS-1:0] lock_map
);
    typedef struct packed {
        logic [NUM_LOCKS-1:0] locks;
        logic                 rv0;
        logic [NUM_LOCKS-1:0] rd0;
        logic                 rv1;
        logic [NUM_LOCKS-1:0] rd1;
    } state_t;

    state_t state_d, state_q;

    logic [SPL_PORTS-1:0]                req_v;
    spl_op_e                             op_v  [SPL_PORTS];
    logic [IDX_W-1:0]                    idx_v [SPL_PORTS];
    logic [SPL_PORTS-1:0][NUM_LOCKS-1:0] claim_hit;
    logic [SPL_PORTS-1:0][NUM_LOCKS-1:0] free_hit;
    logic [NUM_LOCKS-1:0]                grant0, grant1, held_next;

    assign req_v    = {p1_req, p0_req};
    assign op_v[0]  = spl_op_e'(p0_we);
    assign op_v[1]  = spl_op_e'(p1_we);
    assign idx_v[0] = p0_idx;
    assign idx_v[1] = p1_idx;

    for (genvar p = 0; p < SPL_PORTS; p++) begin : g_port
        spl_decode #(.NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_dec_claim (
            .en  (req_v[p] && (op_v[p] == OP_CLAIM)),
            .idx (idx_v[p]),
            .hit (claim_hit[p])
        );
        spl_decode #(.NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_dec_free (
            .en  (req_v[p] && (op_v[p] == OP_FREE)),
            .idx (idx_v[p]),
            .hit (free_hit[p])
        );
    end

    spl_resolve #(.NUM_LOCKS(NUM_LOCKS)) u_resolve (
        .held      (state_q.locks),
        .free_mask (free_hit[0] | free_hit[1]),
        .want0     (claim_hit[0]),
        .want1     (claim_hit[1]),
        .grant0    (grant0),
        .grant1    (grant1),
        .held_next (held_next)
    );

    always_comb begin
        state_d     = state_q;
        state_d.rv0 = 1'b0;
        state_d.rd0 = '0;
        state_d.rv1 = 1'b0;
        state_d.rd1 = '0;
        if (rst_n) begin
            state_d.locks = held_next;
            state_d.rv0   = p0_req && (op_v[0] == OP_CLAIM);
            state_d.rd0   = grant0;
            state_d.rv1   = p1_req && (op_v[1] == OP_CLAIM);
            state_d.rd1   = grant1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign p0_rvalid = state_q.rv0;
    assign p0_rdata  = state_q.rd0;
    assign p1_rvalid = state_q.rv1;
    assign p1_rdata  = state_q.rd1;
    assign lock_map  = state_q.locks;
endmodule

// File: rtl/spl_checker.sv
module spl_checker #(
    parameter int unsigned NUM_LOCKS = 32,
    localparam int unsigned IDX_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input logic                 clk,
    input logic                 por_n,
    input logic                 rst_n,
    input logic                 p0_req,
    input logic                 p0_we,
    input logic [IDX_W-1:0]     p0_idx,
    input logic                 p1_req,
    input logic                 p1_we,
    input logic [IDX_W-1:0]     p1_idx,
    input logic                 p0_rvalid,
    input logic [NUM_LOCKS-1:0] p0_rdata,
    input logic                 p1_rvalid,
    input logic [NUM_LOCKS-1:0] p1_rdata,
    input logic [NUM_LOCKS-1:0] lock_map
);
    p_claim_held_r2: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && p0_req && !p0_we) |=> lock_map[$past(p0_idx)]);

    p_mask_onehot_r1: assert property (@(posedge clk) disable iff (!por_n)
        p0_rvalid |-> $onehot0(p0_rdata));

    p_single_winner_r6: assert property (@(posedge clk) disable iff (!por_n)
        (p0_rvalid && p1_rvalid) |-> ((p0_rdata & p1_rdata) == '0));

    p_release_r4: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && p0_req && p0_we && !(p1_req && !p1_we && p1_idx == p0_idx))
        |=> !lock_map[$past(p0_idx)]);

    p_rst_keeps_r9: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> ($stable(lock_map) && !p0_rvalid && !p1_rvalid));

    p_no_write_resp_r11: assert property (@(posedge clk) disable iff (!por_n)
        p1_rvalid |-> $past(rst_n && p1_req && !p1_we));
endmodule

bind spinlock_bank spl_checker #(.NUM_LOCKS(NUM_LOCKS)) u_spl_checker (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .p0_req    (p0_req),
    .p0_we     (p0_we),
    .p0_idx    (p0_idx),
    .p1_req    (p1_req),
    .p1_we     (p1_we),
    .p1_idx    (p1_idx),
    .p0_rvalid (p0_rvalid),
    .p0_rdata  (p0_rdata),
    .p1_rvalid (p1_rvalid),
    .p1_rdata  (p1_rdata),
    .lock_map  (lock_map)
);

// File: tb/spinlock_bank_bench.sv
module spinlock_bank_bench;
    localparam int unsigned NL = 32;
    localparam int unsigned IW = 5;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          rst_n = 1'b0;
    logic          p0_req = 1'b0, p0_we = 1'b0, p1_req = 1'b0, p1_we = 1'b0;
    logic [IW-1:0] p0_idx = '0, p1_idx = '0;
    logic          p0_rvalid, p1_rvalid;
    logic [NL-1:0] p0_rdata, p1_rdata, lock_map;

    always #10 clk = ~clk;

    spinlock_bank #(.NUM_LOCKS(NL)) u_spinlock_bank (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .p0_req(p0_req), .p0_we(p0_we), .p0_idx(p0_idx),
        .p1_req(p1_req), .p1_we(p1_we), .p1_idx(p1_idx),
        .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
        .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata),
        .lock_map(lock_map)
    );

    int nchk  = 0;
    int nfail = 0;

    typedef struct {
        logic          v0;
        logic [NL-1:0] d0;
        logic          v1;
        logic [NL-1:0] d1;
    } exp_t;

    exp_t  expq [$];
    string tagq [$];
    logic [NL-1:0] mdl = '0;

    task automatic check(input logic [NL-1:0] act, input logic [NL-1:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compares each cycle's responses against the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (expq.size() > 0) begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check(NL'(p0_rvalid), NL'(e.v0), {t, " p0 rvalid"});
                if (e.v0) check(p0_rdata, e.d0, {t, " p0 rdata"});
                check(NL'(p1_rvalid), NL'(e.v1), {t, " p1 rvalid"});
                if (e.v1) check(p1_rdata, e.d1, {t, " p1 rdata"});
            end
        end
    end

    // Driver: one access cycle per call; predicts from the requirements.
    task automatic cycle(input logic r0, input logic w0, input int i0,
                         input logic r1, input logic w1, input int i1,
                         input string tag);
        exp_t e;
        logic [NL-1:0] rel, g0, g1;
        @(negedge clk);
        p0_req = r0; p0_we = w0; p0_idx = IW'(i0);
        p1_req = r1; p1_we = w1; p1_idx = IW'(i1);
        e.v0 = 1'b0; e.d0 = '0; e.v1 = 1'b0; e.d1 = '0;
        if (rst_n) begin
            rel = '0;
            if (r0 && w0) rel[i0] = 1'b1;
            if (r1 && w1) rel[i1] = 1'b1;
            mdl = mdl & ~rel;
            g0 = '0; g1 = '0;
            if (r0 && !w0) begin
                e.v0 = 1'b1;
                if (!mdl[i0]) begin g0[i0] = 1'b1; mdl[i0] = 1'b1; end
            end
            if (r1 && !w1) begin
                e.v1 = 1'b1;
                if (!mdl[i1]) begin g1[i1] = 1'b1; mdl[i1] = 1'b1; end
            end
            e.d0 = g0; e.d1 = g1;
        end
        expq.push_back(e);
        tagq.push_back(tag);
        @(posedge clk);
        #1;
        check(lock_map, mdl, {tag, " lock_map"});
        p0_req = 1'b0; p1_req = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(lock_map, '0, "R5 reset state");
        check(NL'(p0_rvalid | p1_rvalid), '0, "R5 reset rvalid");
        @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;

        cycle(1, 0, 5, 0, 0, 0, "R1 R2 claim free");
        cycle(1, 0, 5, 0, 0, 0, "R10 re-claim by holder");
        cycle(0, 0, 0, 1, 0, 5, "R3 claim held");
        cycle(1, 0, 0, 1, 0, 31, "R12 two locks");
        cycle(1, 0, 7, 1, 0, 7, "R6 same lock");
        cycle(0, 0, 0, 1, 1, 7, "R4 R11 release");
        cycle(0, 0, 0, 1, 0, 7, "R4 reclaim after release");
        cycle(1, 1, 9, 0, 0, 0, "R11 write free lock");
        cycle(1, 1, 5, 1, 0, 5, "R7 release then claim");
        cycle(1, 1, 0, 1, 0, 0, "R7 release then claim p1");

        @(negedge clk);
        rst_n = 1'b0;
        cycle(1, 0, 12, 1, 1, 31, "R9 ignored in reset");
        cycle(0, 0, 0, 0, 0, 0, "R9 idle in reset");
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1, 0, 12, 0, 0, 0, "R9 claim after reset");

        @(negedge clk);
        check(lock_map === '0 ? 1 : 0, 0, "R8 bank non-empty before clear");
        por_n = 1'b0;
        #1;
        mdl = '0;
        check(lock_map, '0, "R8 power-on clear");
        @(negedge clk);
        por_n = 1'b1;

        for (int i = 0; i < NL; i++) cycle(1, 0, i, 0, 0, 0, "R1 sweep claim");
        for (int i = 0; i < NL; i++) cycle(0, 0, 0, 1, 0, i, "R3 sweep held");
        for (int i = 0; i < NL; i++) cycle(0, 0, 0, 1, 1, i, "R4 sweep release");
        check(lock_map, '0, "R5 all cleared by writes");

        cycle(0, 0, 0, 0, 0, 0, "drain");
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule